// File: doc/BRIEF.md
# Lagged Fibonacci Random Number Generator

This block produces a stream of 31-bit pseudo-random values from an additive lagged recurrence. It keeps the last 17 words of a 32-bit sequence in a small circular store. Each new word is the sum, modulo 2^32, of the word 17 places back and the word 5 places back. The upper 31 bits of each new word are returned to the requester.

A user seed in the range 0 to 2,147,483,646 starts a built-in seeding pass. The pass runs a multiplicative congruential sequence, x ← 16807·x mod (2^31−1), and writes one value into each of the 17 words. A fix-up on word 0 then puts the store in canonical form, so that each legal seed gives its own cycle of outputs. Reset starts the same pass with seed 0, so the generator always holds a valid state.

The consumer raises `next_req` and receives one value per accepted cycle on `rnd_out`, marked by `rnd_valid`. While `busy` is high, requests are not accepted.

Top module: `lfg_rng`

## Requirements
- R1: In every cycle that reset is high, `rnd_valid` is 0 and `busy` is 1. Reset starts a seeding pass with seed 0, which ends no more than 20 cycles after reset is released.
- R2: A `seed_load` pulse makes `busy` read 1 for exactly 17 cycles, counted from the cycle after the load. While `busy` is 1, `next_req` is not acknowledged: `rnd_valid` stays 0 and the later output stream is unchanged.
- R3: The seeding pass starts from seed+1 and steps x ← 16807·x mod (2^31−1). Word i (0..16) receives the value after i+1 steps, zero-extended to 32 bits. The residue 2^31−1 is kept as itself, so the largest legal seed fills every word with 0x7FFFFFFF.
- R4: After seeding, bit 0 of word 0 is forced to 1 (canonical form).
- R5: Each accepted request forms the new word x[n] = x[n−17] + x[n−5] mod 2^32. The words filled in seeding count as x[0]..x[16], so the first new word is word0 + word12. The new word replaces the oldest entry, and both operands are read before that entry is overwritten.
- R6: `rnd_out` is bits 31..1 of the new word. It is valid, with `rnd_valid` = 1, in the cycle after the accepted request.
- R7: Each cycle with `next_req` = 1 while not busy gives exactly one result. A cycle without a request gives `rnd_valid` = 0 and does not advance the sequence.
- R8: A `seed_load` during a seeding pass restarts the pass from the new seed, and the 17-cycle busy count starts again.
- R9: When `seed_load` and `next_req` are high in the same cycle, the load wins. No result is produced, and the stream comes from the new seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_in | input | 31 | Seed, legal range 0..2,147,483,646 |
| seed_load | input | 1 | Start seeding from `seed_in` |
| busy | output | 1 | Seeding pass in progress |
| next_req | input | 1 | Request one random value |
| rnd_valid | output | 1 | `rnd_out` holds a fresh value |
| rnd_out | output | 31 | Random value, upper 31 bits of the new word |

## Verification
The stream is compared against a bench model for seed 0 (taken through reset), for seed 1, for the largest legal seed, for a mid-range seed and for several seeds drawn at random. Seeds 0 and 1 differ only in their low bits, so together they show whether the start offset and the word-0 fix-up are applied. The largest seed exercises the residue that the modulus keeps as itself. Request gaps are drawn at random, so an advance on an idle cycle shows up as a mismatch. Directed cases cover a request held high through a seeding pass, a reload in the middle of seeding, and a load that arrives together with a request.

// File: rtl/lfg_pkg.sv
package lfg_pkg;
  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_SEED = 1'b1
  } lfg_mode_e;
endpackage

// File: rtl/lfg_mcg_step.sv
// One step of x <- MULT*x mod (2^W - 1), folded without a divider.
// An input equal to the modulus maps to itself (the residue is kept).
module lfg_mcg_step #(
  parameter int W    = 31,
  parameter int MULT = 16807
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  localparam int MW = $clog2(MULT + 1);
  localparam int PW = W + MW;
  localparam logic [W:0] MODV = {1'b0, {W{1'b1}}};

  logic [PW-1:0] prod;
  logic [W:0]    fold;

  always_comb begin
    prod = PW'(x) * PW'(MULT);
    fold = {1'b0, prod[W-1:0]} + (W+1)'(prod[PW-1:W]);
    if (fold > MODV) y = W'(fold - MODV);
    else             y = fold[W-1:0];
  end
endmodule

// File: rtl/lfg_lag_ram.sv
// Lag store: one write port, two asynchronous read ports (LUT RAM style).
// Reads see the old contents in the cycle of the write.
module lfg_lag_ram #(
  parameter int DEPTH = 17,
  parameter int W     = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  // R5: every write and read stays inside the circular store
  assert_addr_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    (!we || (int'(waddr) < DEPTH)) && (int'(raddr_a) < DEPTH) && (int'(raddr_b) < DEPTH));
endmodule

// File: rtl/lfg_rng.sv
module lfg_rng
  import lfg_pkg::*;
#(
  parameter int LAG_LONG  = 17,
  parameter int LAG_SHORT = 5,
  parameter int WORD_W    = 32,
  parameter int MULT      = 16807
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-2:0] seed_in,
  input  logic              seed_load,
  output logic              busy,
  input  logic              next_req,
  output logic              rnd_valid,
  output logic [WORD_W-2:0] rnd_out
);
  localparam int AW        = $clog2(LAG_LONG);
  localparam int SHORT_OFS = LAG_LONG - LAG_SHORT;
  localparam int SW        = WORD_W - 1;
  localparam logic [AW-1:0] LAST = AW'(LAG_LONG - 1);

  lfg_mode_e       mode;
  logic [AW-1:0]   fill_idx;
  logic [AW-1:0]   head;
  logic [AW-1:0]   tap_idx;
  logic [AW:0]     tap_raw;
  logic [SW-1:0]   lcg_q;
  logic [SW-1:0]   lcg_d;
  logic [WORD_W-1:0] old_word;
  logic [WORD_W-1:0] tap_word;
  logic [WORD_W-1:0] sum_word;
  logic [WORD_W-1:0] seed_word;
  logic [WORD_W-1:0] wr_data;
  logic [AW-1:0]   wr_addr;
  logic            wr_en;
  logic            seeding;
  logic            accept;

  assign busy    = (mode == MODE_SEED);
  assign seeding = !rst && !seed_load && (mode == MODE_SEED);
  assign accept  = !rst && !seed_load && (mode == MODE_RUN) && next_req;

  // Short-lag tap: LAG_SHORT words back equals head + (LAG_LONG - LAG_SHORT) mod LAG_LONG
  always_comb begin
    tap_raw = {1'b0, head} + (AW+1)'(SHORT_OFS);
    if (tap_raw >= (AW+1)'(LAG_LONG)) tap_idx = AW'(tap_raw - (AW+1)'(LAG_LONG));
    else                               tap_idx = tap_raw[AW-1:0];
  end

  lfg_mcg_step #(.W(SW), .MULT(MULT)) u_step (
    .x (lcg_q),
    .y (lcg_d)
  );

  lfg_lag_ram #(.DEPTH(LAG_LONG), .W(WORD_W), .AW(AW)) u_ram (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_en),
    .waddr   (wr_addr),
    .wdata   (wr_data),
    .raddr_a (head),
    .rdata_a (old_word),
    .raddr_b (tap_idx),
    .rdata_b (tap_word)
  );

  always_comb begin
    sum_word  = old_word + tap_word;
    seed_word = {1'b0, lcg_d};
    if (fill_idx == '0) seed_word[0] = 1'b1;  // canonical-form fix-up on word 0
    wr_en   = seeding || accept;
    wr_addr = seeding ? fill_idx : head;
    wr_data = seeding ? seed_word : sum_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= MODE_SEED;
      fill_idx  <= '0;
      head      <= '0;
      lcg_q     <= SW'(1);
      rnd_valid <= 1'b0;
      rnd_out   <= '0;
    end else begin
      rnd_valid <= 1'b0;
      if (seed_load) begin
        mode     <= MODE_SEED;
        fill_idx <= '0;
        lcg_q    <= seed_in + SW'(1);
      end else if (mode == MODE_SEED) begin
        lcg_q <= lcg_d;
        if (fill_idx == LAST) begin
          mode <= MODE_RUN;
          head <= '0;
        end else begin
          fill_idx <= fill_idx + AW'(1);
        end
      end else if (next_req) begin
        rnd_valid <= 1'b1;
        rnd_out   <= sum_word[WORD_W-1:1];
        head      <= (head == LAST) ? '0 : head + AW'(1);
      end
    end
  end

  // R8: a load always enters seeding
  assert_load_enters_seed_R8: assert property (@(posedge clk) disable iff (rst)
    seed_load |=> busy);
  // R2: seeding ends after the last word is written
  assert_seed_ends_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && !seed_load && fill_idx == LAST) |=> !busy);
  // R2: no acknowledge while busy
  assert_no_ack_busy_R2: assert property (@(posedge clk) disable iff (rst)
    busy |=> !rnd_valid);
  // R7: a request while running gives one result
  assert_accept_gives_result_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && next_req && !seed_load) |=> rnd_valid);
  // R7: no request, no result
  assert_idle_no_result_R7: assert property (@(posedge clk) disable iff (rst)
    !next_req |=> !rnd_valid);
  // R9: load beats a simultaneous request
  assert_load_priority_R9: assert property (@(posedge clk) disable iff (rst)
    (seed_load && next_req) |=> !rnd_valid);
  // R3: the congruential state never collapses to zero
  assert_lcg_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (lcg_d != '0));
endmodule

// File: tb/lfg_rng_test.sv
module lfg_rng_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [30:0] seed_in = '0;
  logic        seed_load = 1'b0;
  logic        busy;
  logic        next_req = 1'b0;
  logic        rnd_valid;
  logic [30:0] rnd_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] mdl [17];
  int          mhead;

  always #5 clk = ~clk;

  lfg_rng uut (
    .clk(clk), .rst(rst), .seed_in(seed_in), .seed_load(seed_load),
    .busy(busy), .next_req(next_req), .rnd_valid(rnd_valid), .rnd_out(rnd_out)
  );

  function automatic logic [30:0] mstep(logic [30:0] x);
    if (x == 31'h7FFFFFFF) return x;
    return 31'((64'(x) * 64'd16807) % 64'd2147483647);
  endfunction

  function automatic void model_seed(logic [30:0] s);
    logic [30:0] x;
    x = s + 31'd1;
    for (int i = 0; i < 17; i++) begin
      x = mstep(x);
      mdl[i] = {1'b0, x};
    end
    mdl[0][0] = 1'b1;
    mhead = 0;
  endfunction

  function automatic logic [30:0] model_next();
    logic [31:0] w;
    w = mdl[mhead] + mdl[(mhead + 12) % 17];
    mdl[mhead] = w;
    mhead = (mhead + 1) % 17;
    return w[31:1];
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_busy(int expect_len, string req);
    int cnt = 0;
    while (busy && cnt < 40) begin
      check(!rnd_valid, req, 32'(rnd_valid), 0);
      cnt++;
      @(negedge clk);
    end
    check(cnt == expect_len, req, cnt, expect_len);
  endtask

  task automatic do_load(logic [30:0] s);
    seed_in = s;
    seed_load = 1'b1;
    @(negedge clk);
    seed_load = 1'b0;
    model_seed(s);
  endtask

  task automatic gen(int n, int density);
    for (int i = 0; i < n; i++) begin
      bit r;
      r = ($urandom % 100) < density;
      next_req = r;
      @(negedge clk);
      if (r) begin
        logic [30:0] e;
        e = model_next();
        check(rnd_valid && rnd_out == e, "R3 R4 R5 R6 stream", {rnd_valid, rnd_out}, {1'b1, e});
      end else begin
        check(!rnd_valid, "R7 idle", 32'(rnd_valid), 0);
      end
    end
    next_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!rnd_valid && busy, "R1 reset", {rnd_valid, busy}, 32'b01);
    rst = 1'b0;
    begin
      int c = 0;
      while (busy && c < 25) begin @(negedge clk); c++; end
      check(c <= 20, "R1 reset seeding ends", c, 20);
    end
    model_seed(31'd0);
    gen(3000, 80);

    // R2: requests held high through a seeding pass are not acknowledged
    next_req = 1'b1;
    do_load(31'd1);
    wait_busy(17, "R2 busy");
    next_req = 1'b0;
    gen(3000, 70);

    do_load(31'd2147483646);
    wait_busy(17, "R2 busy max seed");
    gen(3000, 90);

    do_load(31'd12345);
    wait_busy(17, "R2 busy mid seed");
    gen(2000, 50);

    // R8: reload during seeding restarts the pass
    do_load(31'd777);
    repeat (4) @(negedge clk);
    do_load(31'd987654321);
    wait_busy(17, "R8 restart");
    gen(2000, 85);

    // R9: load together with a request
    gen(5, 100);
    seed_in = 31'd42;
    seed_load = 1'b1;
    next_req = 1'b1;
    @(negedge clk);
    seed_load = 1'b0;
    next_req = 1'b0;
    model_seed(31'd42);
    check(!rnd_valid && busy, "R9 load priority", {rnd_valid, busy}, 32'b01);
    @(negedge clk);
    wait_busy(16, "R9 busy");
    gen(1000, 80);

    for (int k = 0; k < 3; k++) begin
      do_load(31'($urandom % 32'd2147483647));
      wait_busy(17, "R2 busy random seed");
      gen(2000, 75);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule